// File: doc/BRIEF.md
# Framed Command Stream Register Decoder

This block sits behind a byte-wide transport and turns a framed command stream into writes on a display controller's video register file. Each command opens with the lead byte 0xAF and an opcode. A register-write command carries an address byte and a data byte. A copy command carries seven bytes of fields, which the block hands to the blitting logic on a small output port with a one-cycle strobe.

The register file has two banks. The staged bank receives every register write. The active bank drives the timing and base-pointer views. A control register at address 0xFF locks and unlocks the bank pair. While the pair is locked, writes reach only the staged bank. An unlock write copies the whole staged bank into the active bank in one clock edge, so a full timing set becomes live at once and never partly.

A byte in the lead position that is not 0xAF sets a sticky framing-error flag. An opcode the block does not know sets the same flag. After either error the parser looks for the next 0xAF. A lone 0xAF can be used as padding at the end of a transfer.

Top module: `cmdstream_regdec`

## Requirements
- R1: After reset the pair is unlocked, `frame_err` and `cp_valid` are 0, and every register reads 0 in both banks.
- R2: The bytes AF 20 a v, with a ≠ 0xFF and the pair unlocked, write v at address a into both banks. The read port shows the new value in the cycle after the last byte is accepted.
- R3: A write of 0x00 to address 0xFF locks the pair. While locked, a register write changes only the staged bank, and the active bank and every view derived from it stay unchanged.
- R4: A write of 0xFF to address 0xFF unlocks the pair and copies all staged registers into the active bank on the same edge. Any other value written to 0xFF leaves the lock state unchanged. Address 0xFF is never stored in either bank, so it always reads 0.
- R5: The bytes AF 6A s2 s1 s0 n d2 d1 d0 set `cp_src`={s2,s1,s0}, `cp_count`=n and `cp_dst`={d2,d1,d0}. `cp_valid` is high for exactly the one cycle after d0 is accepted.
- R6: A byte other than 0xAF in the lead position sets `frame_err`, which stays set until reset. Bytes are then ignored and cause no register write until the next 0xAF.
- R7: An opcode other than 0x20, 0x6A or 0xAF sets `frame_err`, and the parser returns to the lead position.
- R8: An 0xAF in the opcode position is taken as a fresh lead byte and does not raise an error, so padding bytes before a command are harmless.
- R9: The active bank drives these views:
  - `base16` = {r20,r21,r22}
  - `base8` = {r26,r27,r28}
  - `h_active` = {r0F,r10}, high byte at the lower address
  - `pix_clk` = {r1C,r1B}, low byte at the lower address
  - `depth16` = 1 exactly when r00 is 0
- R10: `in_ready` is always 1. A cycle with `in_valid` low does not advance the parser, so gaps between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted (always 1) |
| rd_addr | input | 8 | Register read address |
| rd_staged | output | 8 | Staged bank value at rd_addr |
| rd_active | output | 8 | Active bank value at rd_addr |
| locked | output | 1 | Bank pair locked |
| frame_err | output | 1 | Sticky framing error |
| depth16 | output | 1 | Colour depth register selects 16 bpp |
| base16 | output | 24 | Active 16 bpp frame base pointer |
| base8 | output | 24 | Active 8 bpp frame base pointer |
| h_active | output | 16 | Active horizontal pixel count |
| pix_clk | output | 16 | Active pixel clock value |
| cp_valid | output | 1 | Copy fields valid strobe |
| cp_src | output | 24 | Copy source address |
| cp_count | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that the stream never fits two complete commands into one cycle. A copy takes nine bytes, so a second copy strobe can never follow the first straight away. The stimulus is built at the command level: random writes, lock and unlock writes, copies, stray lead bytes, bad opcodes and padding. Every stray byte is chosen to differ from 0xAF, and every bad opcode is chosen from outside the three legal codes. Random register-write addresses avoid 0xFF; the control register is written only on purpose.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          REG_AW     = 8;
    localparam int          NUM_REGS   = 1 << REG_AW;
    localparam int          COPY_BYTES = 7;
    localparam int          CNT_W      = $clog2(COPY_BYTES);
    localparam int          PTR_W      = 24;

    localparam logic [7:0]  LEAD_BYTE  = 8'hAF;
    localparam logic [7:0]  OP_SETREG  = 8'h20;
    localparam logic [7:0]  OP_COPY    = 8'h6A;
    localparam logic [7:0]  CTL_ADDR   = 8'hFF;
    localparam logic [7:0]  CTL_LOCK   = 8'h00;
    localparam logic [7:0]  CTL_UNLOCK = 8'hFF;

    // register addresses used by the views
    localparam logic [7:0]  A_DEPTH    = 8'h00;
    localparam logic [7:0]  A_HACT     = 8'h0F;
    localparam logic [7:0]  A_PCLK     = 8'h1B;
    localparam logic [7:0]  A_BASE16   = 8'h20;
    localparam logic [7:0]  A_BASE8    = 8'h26;

    typedef enum logic [2:0] {
        PS_LEAD,
        PS_OPCODE,
        PS_ADDR,
        PS_VALUE,
        PS_COPY
    } pstate_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [BYTE_W-1:0] data;
    } regwr_t;

    typedef struct packed {
        logic [PTR_W-1:0]  src;
        logic [BYTE_W-1:0] count;
        logic [PTR_W-1:0]  dst;
    } copy_t;

    function automatic logic [PTR_W-1:0] join_be24(input logic [7:0] hi,
                                                   input logic [7:0] mid,
                                                   input logic [7:0] lo);
        return {hi, mid, lo};
    endfunction

    function automatic logic opcode_known(input logic [7:0] op);
        return (op == OP_SETREG) || (op == OP_COPY) || (op == LEAD_BYTE);
    endfunction

endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmdstream_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_fire,
    input  logic [7:0]        byte_in,
    output logic              wr_fire,
    output regwr_t            wr,
    output logic              cp_fire,
    output logic              cp_last,
    output logic              err_o
);

    pstate_e            st_q, st_d;
    logic [REG_AW-1:0]  addr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               err_q;
    logic               bad;

    always_comb begin
        st_d = st_q;
        bad  = 1'b0;
        unique case (st_q)
            PS_LEAD: begin
                if (byte_in == LEAD_BYTE) st_d = PS_OPCODE;
                else                      bad  = 1'b1;
            end
            PS_OPCODE: begin
                if (byte_in == OP_SETREG)      st_d = PS_ADDR;
                else if (byte_in == OP_COPY)   st_d = PS_COPY;
                else if (byte_in == LEAD_BYTE) st_d = PS_OPCODE;
                else                           st_d = PS_LEAD;
                bad = !opcode_known(byte_in);
            end
            PS_ADDR:  st_d = PS_VALUE;
            PS_VALUE: st_d = PS_LEAD;
            PS_COPY: begin
                if (cnt_q == CNT_W'(COPY_BYTES - 1)) st_d = PS_LEAD;
            end
            default:  st_d = PS_LEAD;
        endcase
    end

    assign wr_fire = byte_fire && (st_q == PS_VALUE);
    assign wr.addr = addr_q;
    assign wr.data = byte_in;
    assign cp_fire = byte_fire && (st_q == PS_COPY);
    assign cp_last = cp_fire && (cnt_q == CNT_W'(COPY_BYTES - 1));
    assign err_o   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_LEAD;
            addr_q <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else if (byte_fire) begin
            st_q <= st_d;
            if (bad) err_q <= 1'b1;
            if (st_q == PS_ADDR) addr_q <= byte_in;
            if (st_q == PS_OPCODE) cnt_q <= '0;
            else if (st_q == PS_COPY) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/reg_banks.sv
module reg_banks
    import cmdstream_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  regwr_t            wr,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [7:0]        rd_staged,
    output logic [7:0]        rd_active,
    output logic              locked_o,
    output logic [7:0]        act_q [NUM_REGS]
);

    logic [7:0] stg_q [NUM_REGS];
    logic       locked_q;
    logic       is_ctl, data_wr, lock_req, unlock_req;

    assign is_ctl     = (wr.addr == CTL_ADDR);
    assign data_wr    = wr_fire && !is_ctl;
    assign lock_req   = wr_fire && is_ctl && (wr.data == CTL_LOCK);
    assign unlock_req = wr_fire && is_ctl && (wr.data == CTL_UNLOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            for (int i = 0; i < NUM_REGS; i++) stg_q[i] <= '0;
        end else begin
            if (lock_req)        locked_q <= 1'b1;
            else if (unlock_req) locked_q <= 1'b0;
            if (data_wr) stg_q[wr.addr] <= wr.data;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)
                act_q[g] <= '0;
            else if (unlock_req)
                act_q[g] <= stg_q[g];
            else if (data_wr && !locked_q && (wr.addr == REG_AW'(g)))
                act_q[g] <= wr.data;
        end
    end

    assign rd_staged = stg_q[rd_addr];
    assign rd_active = act_q[rd_addr];
    assign locked_o  = locked_q;

endmodule

// File: rtl/copy_capture.sv
module copy_capture
    import cmdstream_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cp_fire,
    input  logic       cp_last,
    input  logic [7:0] byte_in,
    output logic       cp_valid,
    output copy_t      fields
);

    localparam int SH_W = COPY_BYTES * BYTE_W;

    logic [SH_W-1:0] sh_q;
    logic            vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= cp_last;
            if (cp_fire) sh_q <= {sh_q[SH_W-BYTE_W-1:0], byte_in};
        end
    end

    assign fields   = copy_t'(sh_q);
    assign cp_valid = vld_q;

endmodule

// File: rtl/cmdstream_regdec.sv
module cmdstream_regdec
    import cmdstream_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_staged,
    output logic [7:0]  rd_active,
    output logic        locked,
    output logic        frame_err,
    output logic        depth16,
    output logic [23:0] base16,
    output logic [23:0] base8,
    output logic [15:0] h_active,
    output logic [15:0] pix_clk,
    output logic        cp_valid,
    output logic [23:0] cp_src,
    output logic [7:0]  cp_count,
    output logic [23:0] cp_dst
);

    logic       byte_fire, wr_fire, cp_fire, cp_last;
    regwr_t     wr;
    copy_t      cpf;
    logic [7:0] act [NUM_REGS];

    assign in_ready  = 1'b1;
    assign byte_fire = in_valid && in_ready;

    cmd_parser u_parse (
        .clk(clk), .rst(rst), .byte_fire(byte_fire), .byte_in(in_data),
        .wr_fire(wr_fire), .wr(wr), .cp_fire(cp_fire), .cp_last(cp_last),
        .err_o(frame_err)
    );

    reg_banks u_banks (
        .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr(wr), .rd_addr(rd_addr),
        .rd_staged(rd_staged), .rd_active(rd_active), .locked_o(locked),
        .act_q(act)
    );

    copy_capture u_copy (
        .clk(clk), .rst(rst), .cp_fire(cp_fire), .cp_last(cp_last),
        .byte_in(in_data), .cp_valid(cp_valid), .fields(cpf)
    );

    assign depth16  = (act[A_DEPTH] == 8'h00);
    assign base16   = join_be24(act[A_BASE16], act[A_BASE16+1], act[A_BASE16+2]);
    assign base8    = join_be24(act[A_BASE8], act[A_BASE8+1], act[A_BASE8+2]);
    assign h_active = {act[A_HACT], act[A_HACT+1]};
    assign pix_clk  = {act[A_PCLK+1], act[A_PCLK]};
    assign cp_src   = cpf.src;
    assign cp_count = cpf.count;
    assign cp_dst   = cpf.dst;

endmodule

module cmdstream_regdec_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        locked,
    input logic        frame_err,
    input logic        cp_valid,
    input logic [23:0] base16,
    input logic [15:0] pix_clk
);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> $past(in_valid && in_ready));

    // R5
    copy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cp_valid |=> !cp_valid);

    // R5
    copy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cp_valid |-> $past(in_valid));

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> (!locked || ($stable(base16) && $stable(pix_clk))));

    // R4
    lock_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(locked) |-> $past(in_valid));

endmodule

bind cmdstream_regdec cmdstream_regdec_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .locked(locked), .frame_err(frame_err), .cp_valid(cp_valid),
    .base16(base16), .pix_clk(pix_clk)
);

// File: tb/sim_cmdstream_regdec.sv
`timescale 1ns/1ps
module sim_cmdstream_regdec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [7:0]  rd_addr = 8'h00;
    logic        in_ready, locked, frame_err, depth16, cp_valid;
    logic [7:0]  rd_staged, rd_active, cp_count;
    logic [23:0] base16, base8, cp_src, cp_dst;
    logic [15:0] h_active, pix_clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] m_stg [256];
    logic [7:0] m_act [256];
    bit         m_lock, m_err;

    always #5 clk = ~clk;

    cmdstream_regdec u0 (.*);

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin m_stg[i] = 0; m_act[i] = 0; end
        m_lock = 0; m_err = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; in_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); in_valid = 1; in_data = b;
    endtask

    task automatic idle();
        @(negedge clk); in_valid = 0; in_data = 8'h00;
    endtask

    task automatic wr_cmd(input logic [7:0] a, input logic [7:0] v);
        send_byte(8'hAF); send_byte(8'h20); send_byte(a); send_byte(v);
        if (a == 8'hFF) begin
            if (v == 8'h00) m_lock = 1;
            else if (v == 8'hFF) begin
                m_lock = 0;
                for (int i = 0; i < 256; i++) m_act[i] = m_stg[i];
            end
        end else begin
            m_stg[a] = v;
            if (!m_lock) m_act[a] = v;
        end
    endtask

    task automatic copy_cmd(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d);
        send_byte(8'hAF); send_byte(8'h6A);
        send_byte(s[23:16]); send_byte(s[15:8]); send_byte(s[7:0]);
        send_byte(n);
        send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a);
        rd_addr = a; #1;
        check({tag, " staged"}, rd_staged, m_stg[a]);
        check({tag, " active"}, rd_active, m_act[a]);
    endtask

    task automatic views_chk(input string tag);
        #1;
        check({tag, " R9 base16"}, base16, {m_act[8'h20], m_act[8'h21], m_act[8'h22]});
        check({tag, " R9 base8"}, base8, {m_act[8'h26], m_act[8'h27], m_act[8'h28]});
        check({tag, " R9 h_active"}, h_active, {m_act[8'h0F], m_act[8'h10]});
        check({tag, " R9 pix_clk"}, pix_clk, {m_act[8'h1C], m_act[8'h1B]});
        check({tag, " R9 depth16"}, depth16, m_act[8'h00] == 8'h00);
        check({tag, " lock"}, locked, m_lock);
        check({tag, " err"}, frame_err, m_err);
    endtask

    function automatic logic [7:0] rand_addr();
        logic [7:0] a;
        a = 8'($urandom_range(0, 254));
        if ($urandom_range(0, 1) == 1) a = 8'($urandom_range(0, 8'h2F));
        return a;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        #1;
        check("R1 locked", locked, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 cp_valid", cp_valid, 0);
        read_chk("R1 reg10", 8'h10);
        read_chk("R1 reg20", 8'h20);
        check("R10 in_ready", in_ready, 1);

        // R2 unlocked write, R9 views
        wr_cmd(8'h20, 8'h12); wr_cmd(8'h21, 8'h34); wr_cmd(8'h22, 8'h56);
        wr_cmd(8'h1B, 8'h34); wr_cmd(8'h1C, 8'h12);
        wr_cmd(8'h0F, 8'h05); wr_cmd(8'h10, 8'h00);
        idle();
        read_chk("R2 reg21", 8'h21);
        check("R9 base16 value", base16, 24'h123456);
        check("R9 pix_clk value", pix_clk, 16'h1234);
        check("R9 h_active value", h_active, 16'h0500);
        wr_cmd(8'h00, 8'h01); idle();
        check("R9 depth16 off", depth16, 0);
        wr_cmd(8'h00, 8'h00); idle();
        check("R9 depth16 on", depth16, 1);

        // R3 lock
        wr_cmd(8'hFF, 8'h00); wr_cmd(8'h20, 8'h77); idle();
        check("R3 locked", locked, 1);
        read_chk("R3 reg20", 8'h20);
        check("R3 base16 held", base16, 24'h123456);
        // R4 other value on control does nothing
        wr_cmd(8'hFF, 8'h5A); idle();
        check("R4 still locked", locked, 1);
        // R4 unlock commits
        wr_cmd(8'hFF, 8'hFF); idle();
        check("R4 unlocked", locked, 0);
        check("R4 base16 committed", base16, 24'h773456);
        read_chk("R4 regFF", 8'hFF);

        // R5 copy with gaps (R10)
        send_byte(8'hAF); idle(); send_byte(8'h6A); idle();
        send_byte(8'h01); send_byte(8'h02); idle(); send_byte(8'h03);
        send_byte(8'h40); send_byte(8'hA0); idle(); send_byte(8'hB0);
        send_byte(8'hC0); idle(); #1;
        check("R5 cp_valid pulse", cp_valid, 1);
        check("R5 src", cp_src, 24'h010203);
        check("R5 count", cp_count, 8'h40);
        check("R5 dst", cp_dst, 24'hA0B0C0);
        idle(); #1;
        check("R5 cp_valid drop", cp_valid, 0);
        check("R10 gaps no error", frame_err, 0);

        // R8 padding
        send_byte(8'hAF); wr_cmd(8'h01, 8'h09);
        send_byte(8'hAF); send_byte(8'hAF); idle();
        check("R8 no err", frame_err, 0);
        read_chk("R8 reg01", 8'h01);

        // R6 junk in lead position
        send_byte(8'h11); send_byte(8'h20); send_byte(8'h05); send_byte(8'h66);
        m_err = 1;
        idle();
        check("R6 err set", frame_err, 1);
        read_chk("R6 reg05 untouched", 8'h05);
        wr_cmd(8'h05, 8'h3C); idle();
        read_chk("R6 resync", 8'h05);
        check("R6 sticky", frame_err, 1);

        // R7 bad opcode
        do_reset();
        send_byte(8'hAF); send_byte(8'h33); m_err = 1; wr_cmd(8'h06, 8'h21); idle();
        check("R7 err", frame_err, 1);
        read_chk("R7 recover", 8'h06);

        // random mix
        do_reset();
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [7:0] a;
            kind = $urandom_range(0, 19);
            if (kind < 11) begin
                a = rand_addr();
                wr_cmd(a, 8'($urandom));
                idle();
                read_chk("R2 R3 rand", a);
            end else if (kind < 13) begin
                wr_cmd(8'hFF, 8'h00); idle();
            end else if (kind < 15) begin
                wr_cmd(8'hFF, 8'hFF); idle();
                read_chk("R4 rand commit", rand_addr());
            end else if (kind < 17) begin
                logic [23:0] s, d; logic [7:0] c;
                s = 24'($urandom); d = 24'($urandom); c = 8'($urandom);
                copy_cmd(s, c, d); idle(); #1;
                check("R5 rand valid", cp_valid, 1);
                check("R5 rand fields", {cp_src, cp_count, cp_dst}, {s, c, d});
            end else if (kind == 17) begin
                logic [7:0] j;
                j = 8'($urandom_range(0, 8'hAE));
                send_byte(j); m_err = 1; idle();
            end else if (kind == 18) begin
                logic [7:0] op;
                op = 8'($urandom_range(0, 255));
                if (op == 8'h20 || op == 8'h6A || op == 8'hAF) op = 8'h55;
                send_byte(8'hAF); send_byte(op); m_err = 1; idle();
            end else begin
                send_byte(8'hAF); idle();
            end
            views_chk("R6 R7 R8 rand");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule